// File: doc/BRIEF.md
# Reset Cause and Stop Event Flag Register

This block is an 8-bit register that records which source caused the most recent reset and whether the system has entered stop mode. Four one-cycle reset-source pulses feed a prioritised encoder. The encoder writes a two-bit cause code into storage that only the power-on reset clears, so the code is still readable once the system reset it describes has been released.

A stop-mode entry strobe arms a pending set of the stop-event flag. The set takes effect on the clock edge that ends the current instruction. A read made during that same instruction therefore still returns 0, and the next read returns 1.

Software can write the stop flag and a divider-select control bit. The cause bits are read-only. The remaining bit positions carry status from a neighbouring clock controller, and the whole register is presented combinationally on the read port.

Top module: `rst_cause_reg`

## Requirements
- R1: The cause code sits in bits [6:5] and is encoded as 00 for external pin, 01 for software halt, 10 for watchdog and 11 for low-voltage detect. With the neighbour inputs at 0 and the stop flag clear, the register reads 0000_1000, 0010_1000, 0100_1000 or 0110_1000 respectively, one cycle after the source pulse.
- R2: When several sources pulse in the same cycle, the code is taken from the highest-priority one. The order is low-voltage, then watchdog, then software, then external.
- R3: The cause code survives an assertion of rst_ni. Only por_ni clears it, and it clears it to 00.
- R4: A write to bits 6 and 5 is ignored. The cause code changes only when a reset-source pulse arrives.
- R5: A stop_req_i strobe arms a pending set. On the first clock edge where eoi_i is high (the edge may fall in the strobe's own cycle), bit 7 becomes 1. A read during the eoi_i cycle returns 0 in bit 7, and a read in the following cycle returns 1.
- R6: A write sets or clears bit 7 to the value of wr_data_i[7].
- R7: If a write of 0 to bit 7 and a deferred set land on the same edge, bit 7 ends at 1.
- R8: Bit 3 (div_sel_o) resets to 1 on rst_ni and follows wr_data_i[3] on a write.
- R9: Bits 4, 2, 1 and 0 reflect nbr_i[3], nbr_i[2], nbr_i[1] and nbr_i[0], and a write has no effect on them.
- R10: rst_ni clears bit 7 and drops any pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset, clears the cause code |
| ext_rst_i | input | 1 | External pin reset pulse |
| sw_rst_i | input | 1 | Software halt reset pulse |
| wdg_rst_i | input | 1 | Watchdog reset pulse |
| lvd_rst_i | input | 1 | Low-voltage detect reset pulse |
| stop_req_i | input | 1 | Stop-mode entry strobe |
| eoi_i | input | 1 | End of current instruction |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| nbr_i | input | 4 | Neighbour status for bits 4, 2, 1, 0 |
| rd_data_o | output | 8 | Full register value |
| div_sel_o | output | 1 | Divider-select control bit (bit 3) |

## Verification
The cause encoder is exercised in three ways:
- Each single source is pulsed alone, which confirms every one of the four code values.
- Pairs, triples and all four sources are pulsed together, which distinguishes true priority from a simple OR of the code bits.
- A source is pulsed while rst_ni is low, and system and power-on resets are then applied separately, which separates the two reset domains.

The stop flag is exercised in several ways:
- The strobe and end of instruction are driven apart and then together, which shows the set is deferred rather than immediate.
- A clearing write is made to coincide with the set, which checks the set-wins rule.
- rst_ni is asserted while a set is pending, which checks that the pending set is dropped.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int REG_W  = 8;
  localparam int N_SRC  = 4;
  localparam int CODE_W = 2;
  // source index equals its code; higher index has priority
  localparam int SRC_EXT = 0;
  localparam int SRC_SW  = 1;
  localparam int SRC_WDG = 2;
  localparam int SRC_LVD = 3;
  localparam int BIT_STOP = 7;
  localparam int BIT_DIV  = 3;
  localparam logic DIV_RST = 1'b1;

  typedef enum logic [CODE_W-1:0] {
    CAUSE_EXT = 2'b00,
    CAUSE_SW  = 2'b01,
    CAUSE_WDG = 2'b10,
    CAUSE_LVD = 2'b11
  } cause_e;
endpackage

// File: rtl/rcf_cause_store.sv
module rcf_cause_store
  import rcf_pkg::*;
(
  input  logic               clk_i,
  input  logic               por_ni,
  input  logic [N_SRC-1:0]   src_i,
  output cause_e             cause_o
);
  cause_e cause_q, cause_d;
  logic   hit;

  always_comb begin
    cause_d = cause_q;
    hit     = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (src_i[i]) begin
        cause_d = cause_e'(i[CODE_W-1:0]);
        hit     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)  cause_q <= CAUSE_EXT;
    else if (hit) cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rcf_stop_flag.sv
module rcf_stop_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic eoi_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic flag_o
);
  logic pend_q, flag_q, set_now;

  assign set_now = eoi_i & (pend_q | stop_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (set_now)         pend_q <= 1'b0;
      else if (stop_req_i) pend_q <= 1'b1;
      if (set_now)         flag_q <= 1'b1;
      else if (wr_en_i)    flag_q <= wr_bit_i;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              ext_rst_i,
  input  logic              sw_rst_i,
  input  logic              wdg_rst_i,
  input  logic              lvd_rst_i,
  input  logic              stop_req_i,
  input  logic              eoi_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [3:0]        nbr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              div_sel_o
);
  logic [N_SRC-1:0] src;
  cause_e           cause;
  logic             stop_flag;
  logic             div_q;
  logic             unused_wr;

  assign src[SRC_EXT] = ext_rst_i;
  assign src[SRC_SW]  = sw_rst_i;
  assign src[SRC_WDG] = wdg_rst_i;
  assign src[SRC_LVD] = lvd_rst_i;

  rcf_cause_store u_cause (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .src_i   (src),
    .cause_o (cause)
  );

  rcf_stop_flag u_stop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_req_i (stop_req_i),
    .eoi_i      (eoi_i),
    .wr_en_i    (wr_en_i),
    .wr_bit_i   (wr_data_i[BIT_STOP]),
    .flag_o     (stop_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= DIV_RST;
    else if (wr_en_i) div_q <= wr_data_i[BIT_DIV];
  end

  assign unused_wr = ^{wr_data_i[6:4], wr_data_i[2:0]};

  assign rd_data_o = {stop_flag, cause, nbr_i[3], div_q, nbr_i[2:0]};
  assign div_sel_o = div_q;
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_ni,
  input logic       ext_rst_i,
  input logic       sw_rst_i,
  input logic       wdg_rst_i,
  input logic       lvd_rst_i,
  input logic       stop_req_i,
  input logic       eoi_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       div_sel_o
);
  // R2
  lvd_pri_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    lvd_rst_i |=> rd_data_o[6:5] == 2'b11);
  // R2
  wdg_pri_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (wdg_rst_i && !lvd_rst_i) |=> rd_data_o[6:5] == 2'b10);
  // R1
  sw_code_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (sw_rst_i && !wdg_rst_i && !lvd_rst_i) |=> rd_data_o[6:5] == 2'b01);
  // R1
  ext_code_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (ext_rst_i && !sw_rst_i && !wdg_rst_i && !lvd_rst_i) |=> rd_data_o[6:5] == 2'b00);
  // R4
  cause_hold_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    !(ext_rst_i || sw_rst_i || wdg_rst_i || lvd_rst_i) |=> $stable(rd_data_o[6:5]));
  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && stop_req_i) |=> rd_data_o[7]);
  // R5
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[7]) |-> $past(eoi_i || (wr_en_i && wr_data_i[7])));
  // R6
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[7] && !eoi_i) |=> !rd_data_o[7]);
  // R8
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(div_sel_o));
endmodule

bind rst_cause_reg rst_cause_reg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_ni     (por_ni),
  .ext_rst_i  (ext_rst_i),
  .sw_rst_i   (sw_rst_i),
  .wdg_rst_i  (wdg_rst_i),
  .lvd_rst_i  (lvd_rst_i),
  .stop_req_i (stop_req_i),
  .eoi_i      (eoi_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .div_sel_o  (div_sel_o)
);

// File: tb/rst_cause_reg_tb_top.sv
`timescale 1ns/1ps
module rst_cause_reg_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni, por_ni;
  logic       ext_rst_i, sw_rst_i, wdg_rst_i, lvd_rst_i;
  logic       stop_req_i, eoi_i, wr_en_i;
  logic [7:0] wr_data_i;
  logic [3:0] nbr_i;
  logic [7:0] rd_data_o;
  logic       div_sel_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  rst_cause_reg dut_i (.*);

  // {lvd, wdg, sw, ext}, expected code
  localparam logic [5:0] VEC [10] = '{
    {4'b0001, 2'b00}, {4'b0010, 2'b01}, {4'b0100, 2'b10}, {4'b1000, 2'b11},
    {4'b0011, 2'b01}, {4'b0110, 2'b10}, {4'b1100, 2'b11}, {4'b1001, 2'b11},
    {4'b0111, 2'b10}, {4'b1111, 2'b11}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic pulse_src(logic [3:0] s);
    {lvd_rst_i, wdg_rst_i, sw_rst_i, ext_rst_i} = s;
    tick();
    {lvd_rst_i, wdg_rst_i, sw_rst_i, ext_rst_i} = '0;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 0; por_ni = 0;
    {ext_rst_i, sw_rst_i, wdg_rst_i, lvd_rst_i} = '0;
    stop_req_i = 0; eoi_i = 0; wr_en_i = 0; wr_data_i = '0; nbr_i = '0;
    repeat (3) tick();
    rst_ni = 1; por_ni = 1;
    tick();
    chk("R1 R8 reset value", rd_data_o, 8'b0000_1000);
    chk("R8 div_sel reset", {7'b0, div_sel_o}, 8'd1);

    // R1 R2 vector walk
    foreach (VEC[i]) begin
      pulse_src(VEC[i][5:2]);
      chk($sformatf("R1 R2 vec %0d", i), rd_data_o, {1'b0, VEC[i][1:0], 5'b01000});
    end

    // R3: capture during system reset, survive it, cleared by POR
    rst_ni = 0;
    pulse_src(4'b0100);
    tick();
    rst_ni = 1;
    tick();
    chk("R3 cause kept over rst_ni", rd_data_o, 8'b0100_1000);
    por_ni = 0; tick(); por_ni = 1; tick();
    chk("R3 por clears cause", rd_data_o, 8'b0000_1000);

    // R4 write ignored on cause bits
    pulse_src(4'b1000);
    wr(8'b0000_1000);
    chk("R4 write to cause ignored", rd_data_o, 8'b0110_1000);
    pulse_src(4'b0010);
    wr(8'b0110_1000);
    chk("R4 write of ones ignored", rd_data_o, 8'b0010_1000);

    // R9 neighbour bits
    nbr_i = 4'b1111;
    #0.1;
    chk("R9 neighbour pass", rd_data_o, 8'b0011_1111);
    wr(8'b0000_1000);
    chk("R9 write no effect", rd_data_o, 8'b0011_1111);
    nbr_i = 4'b1010;
    #0.1;
    chk("R9 neighbour pattern", rd_data_o, 8'b0011_1010);
    nbr_i = 4'b0000;

    // R8 divider bit
    wr(8'b0000_0000);
    chk("R8 div cleared by write", {7'b0, div_sel_o}, 8'd0);
    chk("R8 bit3 read", rd_data_o, 8'b0010_0000);
    rst_ni = 0; tick(); rst_ni = 1; tick();
    chk("R8 div back to 1 on reset", rd_data_o, 8'b0010_1000);

    // R5 deferred set, pending held
    stop_req_i = 1; tick(); stop_req_i = 0;
    tick(); tick();
    chk("R5 pending without eoi", {7'b0, rd_data_o[7]}, 8'd0);
    eoi_i = 1;
    #0.1;
    chk("R5 read in same instruction", {7'b0, rd_data_o[7]}, 8'd0);
    tick(); eoi_i = 0;
    chk("R5 next read", {7'b0, rd_data_o[7]}, 8'd1);

    // R6 software write
    wr(8'b0000_1000);
    chk("R6 write clears", {7'b0, rd_data_o[7]}, 8'd0);
    wr(8'b1000_1000);
    chk("R6 write sets", {7'b0, rd_data_o[7]}, 8'd1);
    wr(8'b0000_1000);

    // R5 strobe and eoi in same cycle
    stop_req_i = 1; eoi_i = 1;
    #0.1;
    chk("R5 same-cycle read", {7'b0, rd_data_o[7]}, 8'd0);
    tick(); stop_req_i = 0; eoi_i = 0;
    chk("R5 same-cycle set", {7'b0, rd_data_o[7]}, 8'd1);

    // R7 set beats clear
    wr(8'b0000_1000);
    stop_req_i = 1; eoi_i = 1;
    wr(8'b0000_1000);
    stop_req_i = 0; eoi_i = 0;
    chk("R7 set wins over clear", {7'b0, rd_data_o[7]}, 8'd1);

    // R10 reset clears flag and pending
    stop_req_i = 1; tick(); stop_req_i = 0;
    rst_ni = 0; tick(); rst_ni = 1; tick();
    chk("R10 flag cleared", {7'b0, rd_data_o[7]}, 8'd0);
    eoi_i = 1; tick(); eoi_i = 0; tick();
    chk("R10 pending dropped", {7'b0, rd_data_o[7]}, 8'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule